// File: doc/BRIEF.md
# Partially Adaptive Mesh Route Selector

This block computes the allowed next hops for one packet in a three-dimensional mesh. It sits in one dimension module of a router that is split into one module per dimension. It compares the coordinates of the current node with those of the destination and finds the routing dimension, which is the lowest dimension where the two differ. It then offers up to two candidate hops.

The first candidate is always the dimension-order hop. It is in the routing dimension, moves toward the destination and uses virtual-channel class 0. The second candidate is optional. It is a hop toward the destination in the next higher dimension and uses class 1. It is offered only when the routing dimension is not the highest one and the current coordinate in the routing dimension has the right parity for the direction of travel.

Each candidate also says whether the packet must first cross inside the node to another dimension module, and which class that crossing uses. When every coordinate matches, the block signals delivery to the local consumer instead of offering hops. A parameter can add one register stage on all outputs.

Top module: `rt_adapt_sel`

## Requirements
- R1: Coordinates are packed with dimension d in bits [3d+2:3d] of `cur_coord` and `dst_coord`, each an unsigned 3-bit value. When all three fields are equal, `deliver` is 1 and both `ec_vld` and `ad_vld` are 0. Otherwise `deliver` is 0 and `ec_vld` is 1.
- R2: `ec_dim` is the lowest dimension whose fields differ. `ec_pos` is 1 when the destination field is larger there and 0 when it is smaller, so the hop always shortens the distance. `ec_vc` is 0 (class 0).
- R3: `ad_vld` is 1 only when the routing dimension e is 0 or 1 and the fields of dimension e+1 differ. Then `ad_dim` is e+1, `ad_pos` points toward the destination in that dimension, and `ad_vc` is 1 (class 1).
- R4: The adaptive hop also needs a parity condition. When `ec_pos` is 1, the current field in dimension e must be even. When `ec_pos` is 0, it must be odd. If the parity is wrong, `ad_vld` is 0.
- R5: When the routing dimension is 2, the highest dimension, `ad_vld` is 0 in both directions and the dimension-order hop keeps class 0.
- R6: `ec_xfer` is 1 when `cur_dim` differs from `ec_dim`. `ec_xfer_vc` is 0 when `cur_dim` is below `ec_dim`, which is the in-order move to the next dimension. It is 1 when `cur_dim` is above `ec_dim`, which is a return from the adaptive plane. It is 0 when there is no crossing.
- R7: `ad_xfer` is 1 when `cur_dim` differs from `ad_dim`. `ad_xfer_vc` equals `ad_xfer`.
- R8: With `REG_OUT`=1 (the default), outputs follow the inputs present at the previous rising edge. While `rst_n` is low at an edge, all outputs become 0.
- R9: When a candidate's valid bit is 0, all of its other fields (dim, pos, vc, xfer, xfer_vc) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_coord | input | 9 | Current node coordinates, 3 bits per dimension |
| dst_coord | input | 9 | Destination coordinates, 3 bits per dimension |
| cur_dim | input | 2 | Dimension module currently holding the packet |
| deliver | output | 1 | Packet has arrived; hand it to the local consumer |
| ec_vld | output | 1 | Dimension-order hop offered |
| ec_dim | output | 2 | Dimension of the dimension-order hop |
| ec_pos | output | 1 | 1 for + direction, 0 for - direction |
| ec_vc | output | 1 | Virtual-channel class of the dimension-order hop |
| ec_xfer | output | 1 | Intranode crossing needed before this hop |
| ec_xfer_vc | output | 1 | Class used for that crossing |
| ad_vld | output | 1 | Adaptive hop offered |
| ad_dim | output | 2 | Dimension of the adaptive hop |
| ad_pos | output | 1 | 1 for + direction, 0 for - direction |
| ad_vc | output | 1 | Virtual-channel class of the adaptive hop |
| ad_xfer | output | 1 | Intranode crossing needed before the adaptive hop |
| ad_xfer_vc | output | 1 | Class used for that crossing |

## Verification
The hardest case to reach is the combination that decides the adaptive offer. It needs a given routing dimension, a given direction, a given parity of the current coordinate and a difference in the next dimension, all at once, while `cur_dim` is set both below and above the hop dimension. A directed task builds each parity and direction case by hand. An exhaustive sweep then covers every source and destination in the 4x4x4 corner of the address space with every legal `cur_dim`, and compares the result with an independent model. Extra patterns use field values up to 7 to exercise the full 3-bit compare.

// File: rtl/rs_pkg.sv
// Shared constants and the hop descriptor type for the route selector.
// Assumes a mesh with at most three dimensions, so a dimension index fits in two bits.
package rs_pkg;
    localparam int RS_NDIM = 3;
    localparam int RS_CW   = 3;
    localparam int RS_DW   = $clog2(RS_NDIM + 1);

    typedef struct packed {
        logic             vld;
        logic [RS_DW-1:0] dim;
        logic             pos;
        logic             vc;
        logic             xfer;
        logic             xfer_vc;
    } hop_t;
endpackage

// File: rtl/rs_dim_cmp.sv
// Per-dimension comparison of the current and destination coordinates.
// It reports whether the two differ, the profitable direction, and whether the
// current coordinate's parity allows an adaptive hop into the next dimension.
module rs_dim_cmp #(
    parameter int CW = 3
) (
    input  logic [CW-1:0] cur_c,
    input  logic [CW-1:0] dst_c,
    output logic          differ,
    output logic          pos,
    output logic          par_ok
);
    // compare the fields; + travel needs an even coordinate, - travel an odd one
    always_comb begin
        differ = (cur_c != dst_c);
        pos    = (dst_c > cur_c);
        par_ok = pos ? ~cur_c[0] : cur_c[0];
    end
endmodule

// File: rtl/rs_lowest.sv
// Priority encoder that finds the lowest dimension whose coordinates differ.
// When no bit is set, 'any' is low and the index is zero.
module rs_lowest #(
    parameter int NDIM = 3,
    parameter int DW   = 2
) (
    input  logic [NDIM-1:0] differ,
    output logic            any,
    output logic [DW-1:0]   idx
);
    // scan from the top down so that the lowest set bit wins
    always_comb begin
        any = |differ;
        idx = '0;
        for (int k = NDIM - 1; k >= 0; k--) begin
            if (differ[k]) idx = DW'(k);
        end
    end
endmodule

// File: rtl/rs_hop_build.sv
// Builds the dimension-order and adaptive hop descriptors from the
// per-dimension compare results, the routing dimension and the current module.
// Assumes idx is valid whenever 'any' is high.
module rs_hop_build
    import rs_pkg::*;
#(
    parameter int NDIM = 3,
    parameter int DW   = 2
) (
    input  logic [NDIM-1:0] differ,
    input  logic [NDIM-1:0] pos,
    input  logic [NDIM-1:0] par_ok,
    input  logic            any,
    input  logic [DW-1:0]   idx,
    input  logic [DW-1:0]   cur_dim,
    output logic            deliver,
    output hop_t            ec,
    output hop_t            ad
);
    localparam logic [DW-1:0] TOP_DIM = DW'(NDIM - 1);

    logic [DW-1:0] nxt;
    logic          can_adapt;

    // next dimension and the adaptive admission condition
    always_comb begin
        nxt       = idx + DW'(1);
        can_adapt = 1'b0;
        if (any && (idx < TOP_DIM)) begin
            can_adapt = differ[nxt] && par_ok[idx];
        end
    end

    // dimension-order hop descriptor, class 0 on the link
    always_comb begin
        ec = '0;
        if (any) begin
            ec.vld     = 1'b1;
            ec.dim     = idx;
            ec.pos     = pos[idx];
            ec.vc      = 1'b0;
            ec.xfer    = (cur_dim != idx);
            ec.xfer_vc = (cur_dim > idx);
        end
    end

    // adaptive hop descriptor, class 1 on the link and for any crossing
    always_comb begin
        ad = '0;
        if (can_adapt) begin
            ad.vld     = 1'b1;
            ad.dim     = nxt;
            ad.pos     = pos[nxt];
            ad.vc      = 1'b1;
            ad.xfer    = (cur_dim != nxt);
            ad.xfer_vc = (cur_dim != nxt);
        end
    end

    // arrival when no dimension differs
    always_comb deliver = ~any;
endmodule

// File: rtl/rt_adapt_sel.sv
// Top of the partially adaptive route selector for one dimension module.
// It compares each dimension, picks the routing dimension, builds up to two
// candidate hops and can register all outputs. It assumes cur_dim holds a module index.
module rt_adapt_sel
    import rs_pkg::*;
#(
    parameter int NDIM    = RS_NDIM,
    parameter int CW      = RS_CW,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NDIM*CW-1:0]   cur_coord,
    input  logic [NDIM*CW-1:0]   dst_coord,
    input  logic [RS_DW-1:0]     cur_dim,
    output logic                 deliver,
    output logic                 ec_vld,
    output logic [RS_DW-1:0]     ec_dim,
    output logic                 ec_pos,
    output logic                 ec_vc,
    output logic                 ec_xfer,
    output logic                 ec_xfer_vc,
    output logic                 ad_vld,
    output logic [RS_DW-1:0]     ad_dim,
    output logic                 ad_pos,
    output logic                 ad_vc,
    output logic                 ad_xfer,
    output logic                 ad_xfer_vc
);
    localparam int DW = RS_DW;

    logic [NDIM-1:0] differ;
    logic [NDIM-1:0] pos;
    logic [NDIM-1:0] par_ok;
    logic            any;
    logic [DW-1:0]   idx;
    logic            dlv_c;
    hop_t            ec_c;
    hop_t            ad_c;
    logic            dlv_q;
    hop_t            ec_q;
    hop_t            ad_q;

    for (genvar d = 0; d < NDIM; d++) begin : g_cmp
        rs_dim_cmp #(.CW(CW)) u_cmp (
            .cur_c  (cur_coord[d*CW +: CW]),
            .dst_c  (dst_coord[d*CW +: CW]),
            .differ (differ[d]),
            .pos    (pos[d]),
            .par_ok (par_ok[d])
        );
    end

    rs_lowest #(.NDIM(NDIM), .DW(DW)) u_low (
        .differ (differ),
        .any    (any),
        .idx    (idx)
    );

    rs_hop_build #(.NDIM(NDIM), .DW(DW)) u_build (
        .differ  (differ),
        .pos     (pos),
        .par_ok  (par_ok),
        .any     (any),
        .idx     (idx),
        .cur_dim (cur_dim),
        .deliver (dlv_c),
        .ec      (ec_c),
        .ad      (ad_c)
    );

    if (REG_OUT) begin : g_reg
        // capture the selection each cycle, clearing it under reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dlv_q <= 1'b0;
                ec_q  <= '0;
                ad_q  <= '0;
            end else begin
                dlv_q <= dlv_c;
                ec_q  <= ec_c;
                ad_q  <= ad_c;
            end
        end
    end else begin : g_comb
        // pass the selection straight through
        always_comb begin
            dlv_q = dlv_c;
            ec_q  = ec_c;
            ad_q  = ad_c;
        end
    end

    // unpack the descriptors onto the ports
    always_comb begin
        deliver    = dlv_q;
        ec_vld     = ec_q.vld;
        ec_dim     = ec_q.dim;
        ec_pos     = ec_q.pos;
        ec_vc      = ec_q.vc;
        ec_xfer    = ec_q.xfer;
        ec_xfer_vc = ec_q.xfer_vc;
        ad_vld     = ad_q.vld;
        ad_dim     = ad_q.dim;
        ad_pos     = ad_q.pos;
        ad_vc      = ad_q.vc;
        ad_xfer    = ad_q.xfer;
        ad_xfer_vc = ad_q.xfer_vc;
    end

    // R1: arrival and hop offers never occur together
    p_deliver_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |-> (!ec_vld && !ad_vld));

    // R2: the dimension-order hop always travels on class 0
    p_ec_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ec_vld |-> !ec_vc);

    // R3: an adaptive offer sits one dimension above the dimension-order hop, on class 1
    p_ad_next_dim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ad_vld |-> (ec_vld && ad_vc && (ad_dim == ec_dim + RS_DW'(1))));

    // R5: no adaptive offer while routing in the highest dimension
    p_top_no_adapt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_vld && (ec_dim == RS_DW'(NDIM - 1))) |-> !ad_vld);

    // R7: an adaptive crossing always uses class 1
    p_ad_xfer_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_xfer |-> (ad_vld && ad_xfer_vc));

    // R9: an idle adaptive slot carries no stray fields
    p_ad_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_vld |-> (ad_dim == '0 && !ad_pos && !ad_vc && !ad_xfer && !ad_xfer_vc));
endmodule

// File: tb/rt_adapt_sel_test.sv
module rt_adapt_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cur_coord = '0;
    logic [8:0] dst_coord = '0;
    logic [1:0] cur_dim = '0;
    logic       deliver, ec_vld, ec_pos, ec_vc, ec_xfer, ec_xfer_vc;
    logic       ad_vld, ad_pos, ad_vc, ad_xfer, ad_xfer_vc;
    logic [1:0] ec_dim, ad_dim;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    rt_adapt_sel uut (
        .clk(clk), .rst_n(rst_n), .cur_coord(cur_coord), .dst_coord(dst_coord),
        .cur_dim(cur_dim), .deliver(deliver), .ec_vld(ec_vld), .ec_dim(ec_dim),
        .ec_pos(ec_pos), .ec_vc(ec_vc), .ec_xfer(ec_xfer), .ec_xfer_vc(ec_xfer_vc),
        .ad_vld(ad_vld), .ad_dim(ad_dim), .ad_pos(ad_pos), .ad_vc(ad_vc),
        .ad_xfer(ad_xfer), .ad_xfer_vc(ad_xfer_vc)
    );

    function automatic logic [8:0] pk(input int x, input int y, input int z);
        return {3'(z), 3'(y), 3'(x)};
    endfunction

    // expected {deliver, ec[6:0], ad[6:0]} computed from the requirements
    function automatic logic [14:0] model(input logic [8:0] c, input logic [8:0] d,
                                          input logic [1:0] cd);
        int e = -1;
        int ce, de, cn, dn;
        logic [6:0] ev = '0;
        logic [6:0] av = '0;
        for (int k = 2; k >= 0; k--) if (c[3*k +: 3] != d[3*k +: 3]) e = k;
        if (e < 0) return 15'h4000;
        ce = int'(c[3*e +: 3]);
        de = int'(d[3*e +: 3]);
        ev = {1'b1, 2'(e), (de > ce), 1'b0, (int'(cd) != e), (int'(cd) > e)};
        if (e < 2) begin
            cn = int'(c[3*(e+1) +: 3]);
            dn = int'(d[3*(e+1) +: 3]);
            if (cn != dn && (((de > ce) && (ce % 2 == 0)) || ((de < ce) && (ce % 2 == 1))))
                av = {1'b1, 2'(e + 1), (dn > cn), 1'b1, (int'(cd) != e + 1), (int'(cd) != e + 1)};
        end
        return {1'b0, ev, av};
    endfunction

    function automatic logic [14:0] got_vec();
        return {deliver, ec_vld, ec_dim, ec_pos, ec_vc, ec_xfer, ec_xfer_vc,
                ad_vld, ad_dim, ad_pos, ad_vc, ad_xfer, ad_xfer_vc};
    endfunction

    task automatic chk(input string req, input logic [14:0] g, input logic [14:0] x);
        n_chk++;
        if (g !== x) begin
            n_fail++;
            $display("FAIL %s cur=%h dst=%h cd=%0d got=%h exp=%h", req, cur_coord, dst_coord,
                     cur_dim, g, x);
        end
    endtask

    // drive one pattern, let it through the register, compare field groups
    task automatic apply(input logic [8:0] c, input logic [8:0] d, input logic [1:0] cd,
                         input string ad_req);
        logic [14:0] x, g;
        @(negedge clk);
        cur_coord = c; dst_coord = d; cur_dim = cd;
        @(negedge clk);
        x = model(c, d, cd);
        g = got_vec();
        chk("R1", {g[14], g[13], 6'b0, g[6], 6'b0}, {x[14], x[13], 6'b0, x[6], 6'b0});
        chk("R2", {3'b0, g[12:9], 8'b0}, {3'b0, x[12:9], 8'b0});
        chk("R6", {13'b0, g[8:7]}, {13'b0, x[8:7]});
        chk(ad_req, {8'b0, g[6:2], 2'b0}, {8'b0, x[6:2], 2'b0});
        chk("R7", {13'b0, g[1:0]}, {13'b0, x[1:0]});
        chk("R9", 15'((ec_vld ? 7'b0 : {ec_dim, ec_pos, ec_vc, ec_xfer, ec_xfer_vc})), 15'b0);
        if (ec_vld) begin
            n_chk++;
            if (ec_pos !== (d[3*ec_dim +: 3] > c[3*ec_dim +: 3])) begin
                n_fail++;
                $display("FAIL R2 profit got=%0b exp=%0b", ec_pos, d[3*ec_dim +: 3] > c[3*ec_dim +: 3]);
            end
        end
        if (ad_vld) begin
            n_chk++;
            if (ad_pos !== (d[3*ad_dim +: 3] > c[3*ad_dim +: 3])) begin
                n_fail++;
                $display("FAIL R3 profit got=%0b exp=%0b", ad_pos, d[3*ad_dim +: 3] > c[3*ad_dim +: 3]);
            end
        end
    endtask

    task automatic t_reset();  // R8 reset clears every output
        @(negedge clk);
        cur_coord = pk(1, 2, 3); dst_coord = pk(2, 0, 0); cur_dim = 2'd1;
        @(negedge clk);
        chk("R8", got_vec(), 15'b0);
    endtask

    task automatic t_latency();  // R8 one-cycle latency
        @(negedge clk);
        rst_n = 1'b1;
        cur_coord = pk(3, 3, 3); dst_coord = pk(3, 3, 3); cur_dim = 2'd0;
        @(posedge clk); #1;
        chk("R8", {14'b0, deliver}, 15'd1);
        @(negedge clk);
        cur_coord = pk(0, 3, 3);
        @(posedge clk); #1;  // just past the edge: new value now visible
        chk("R8", {14'b0, deliver}, 15'd0);
        cur_coord = pk(3, 3, 3);
        #2;  // before the next edge the old result must hold
        chk("R8", {14'b0, deliver}, 15'd0);
    endtask

    task automatic t_deliver();  // R1 arrival, including wide field values
        apply(pk(0, 0, 0), pk(0, 0, 0), 2'd0, "R3");
        apply(pk(7, 5, 6), pk(7, 5, 6), 2'd2, "R3");
        apply(pk(7, 5, 6), pk(7, 5, 7), 2'd2, "R3");
    endtask

    task automatic t_parity();  // R4 each direction and parity in dims 0 and 1
        apply(pk(2, 0, 0), pk(5, 3, 0), 2'd0, "R4");  // + even: offered
        apply(pk(3, 0, 0), pk(5, 3, 0), 2'd0, "R4");  // + odd: refused
        apply(pk(5, 0, 0), pk(2, 3, 0), 2'd0, "R4");  // - odd: offered
        apply(pk(6, 0, 0), pk(2, 3, 0), 2'd0, "R4");  // - even: refused
        apply(pk(1, 4, 7), pk(1, 6, 0), 2'd1, "R4");  // dim1 + even
        apply(pk(1, 7, 7), pk(1, 1, 0), 2'd2, "R4");  // dim1 - odd, cur above
        apply(pk(1, 7, 7), pk(1, 1, 7), 2'd0, "R3");  // no diff in next dim
    endtask

    task automatic t_top();  // R5 highest dimension in both directions
        apply(pk(2, 2, 0), pk(2, 2, 7), 2'd2, "R5");
        apply(pk(2, 2, 7), pk(2, 2, 0), 2'd0, "R5");
        apply(pk(4, 4, 3), pk(4, 4, 1), 2'd1, "R5");
    endtask

    task automatic t_sweep();  // R2 R3 R6 R7 every pair in the 4x4x4 region
        for (int s = 0; s < 64; s++)
            for (int t = 0; t < 64; t++)
                for (int m = 0; m < 3; m++)
                    apply(pk(s % 4, (s / 4) % 4, s / 16), pk(t % 4, (t / 4) % 4, t / 16),
                          2'(m), "R3");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_deliver();
        t_parity();
        t_top();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule